// File: doc/BRIEF.md
# Protected Peripheral Clock Prescaler

This block produces a slower peripheral clock from the system clock. A 3-bit ratio code sits in a 16-bit control word. Code zero passes the full system rate through. Any non-zero code N divides the system clock by 2N with a 50% duty cycle. Software reads the control word back at any time. A write changes it only while a separate unlock input is high. Writes without the unlock are dropped silently.

The divided output comes in two forms. The first is a registered clock level, `div_clk`. The second is a single-cycle enable, `div_ce`, so downstream logic can stay in the system clock domain. A small state machine produces both outputs. Its states are `PH_LOW` (low half of a period), `PH_HIGH` (high half of a period) and `PH_BYPASS` (full rate).

The machine has five transitions:
- `PH_LOW -> PH_HIGH` at the end of a low half, when the code is non-zero.
- `PH_LOW -> PH_BYPASS` at the end of a low half, when the code is zero.
- `PH_HIGH -> PH_LOW` at the end of a high half.
- `PH_BYPASS -> PH_HIGH` in the first cycle that a non-zero code is held.
- Reset to `PH_LOW`.

A changed code is taken into use only at a period boundary, which is the end of a low half. A half-cycle is therefore never cut short.

Top module: `pclk_prescaler`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state after that edge. `rdata` reads 0x0002, and `div_clk` and `div_ce` are both 0.
- R2: `rdata` bits 15..3 always read 0, whatever was written. `rdata` bits 2..0 return the current ratio code.
- R3: If `wr_en` and `wr_unlock` are both high at an edge, the code takes `wdata[2:0]` after that edge.
- R4: If `wr_en` is high while `wr_unlock` is low, the write is discarded and the code keeps its value.
- R5: With an active non-zero code N, `div_clk` is high for exactly N cycles and then low for exactly N cycles, giving a period of 2N.
- R6: Outside bypass, `div_ce` is high only in the first cycle of each high half of `div_clk`, which is once per period.
- R7: In bypass, `div_clk` is held low and `div_ce` is high in every cycle.
- R8: The code held in the register is sampled only at the end of a low half. A write made during a period changes neither the rest of that period nor its length.
- R9: Bypass is entered only at the end of a low half, while `div_clk` is low. Bypass is left, with the start of a high half, in the cycle after the register first holds a non-zero code.
- R10: After reset is released with the default code, `div_clk` stays low for 2 cycles and then starts the divide-by-4 pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_unlock | input | 1 | Write-protection enable; a write counts only while this is high |
| wdata | input | 16 | Write data; only bits 2..0 are stored |
| rdata | output | 16 | Read data: the ratio code with the upper bits zero |
| div_clk | output | 1 | Divided clock level (held low in bypass) |
| div_ce | output | 1 | One-cycle enable per divided period; constant high in bypass |

## Verification
A wrong half-cycle count or a wrongly loaded active ratio shows at `div_clk` within one period of the divided clock. It appears as a high or low run of the wrong length. If the machine takes a code before the end of a low half, the running period gets a shortened half at once. A fault in bypass entry or exit shows within the first cycle after the boundary or after the code write, as a `div_ce` value that does not match. A protection fault shows in `rdata` on the cycle right after the write that was issued while locked.

// File: rtl/presc_pkg.sv
package presc_pkg;

    typedef enum logic [1:0] {
        PH_LOW    = 2'd0,
        PH_HIGH   = 2'd1,
        PH_BYPASS = 2'd2
    } phase_e;

endpackage

// File: rtl/presc_ctrl_reg.sv
module presc_ctrl_reg #(
    parameter int RATIO_W    = 3,
    parameter int RESET_CODE = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_unlock,
    input  logic [RATIO_W-1:0] wr_code,
    output logic [RATIO_W-1:0] code_q
);

    localparam logic [RATIO_W-1:0] CODE_INIT = RESET_CODE[RATIO_W-1:0];

    logic accept;
    assign accept = wr_en && wr_unlock;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= CODE_INIT;
        end else if (accept) begin
            code_q <= wr_code;
        end
    end

    // R4: a locked write leaves the code untouched
    a_r4_locked_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_unlock) |=> $stable(code_q));

    // R3: an unlocked write lands on the next edge
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_unlock) |=> (code_q == $past(wr_code)));

endmodule

// File: rtl/presc_divider.sv
module presc_divider
    import presc_pkg::*;
#(
    parameter int RATIO_W    = 3,
    parameter int RESET_CODE = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] code,
    output logic               div_clk,
    output logic               div_ce
);

    localparam logic [RATIO_W-1:0] ONE       = {{(RATIO_W-1){1'b0}}, 1'b1};
    localparam logic [RATIO_W-1:0] ZERO      = '0;
    localparam logic [RATIO_W-1:0] CODE_INIT = RESET_CODE[RATIO_W-1:0];

    phase_e             state_q, state_d;
    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic [RATIO_W-1:0] act_q, act_d;
    logic               half_done;

    assign half_done = (cnt_q == (act_q - ONE));

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_LOW;
            cnt_q   <= ZERO;
            act_q   <= CODE_INIT;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        act_d   = act_q;
        unique case (state_q)
            PH_LOW: begin
                if (half_done) begin
                    cnt_d = ZERO;
                    if (code == ZERO) begin
                        state_d = PH_BYPASS;
                        act_d   = ZERO;
                    end else begin
                        state_d = PH_HIGH;
                        act_d   = code;
                    end
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            PH_HIGH: begin
                if (half_done) begin
                    state_d = PH_LOW;
                    cnt_d   = ZERO;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            PH_BYPASS: begin
                if (code != ZERO) begin
                    state_d = PH_HIGH;
                    act_d   = code;
                    cnt_d   = ZERO;
                end
            end
            default: begin
                state_d = PH_LOW;
                cnt_d   = ZERO;
            end
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            div_clk <= 1'b0;
            div_ce  <= 1'b0;
        end else begin
            div_clk <= (state_d == PH_HIGH);
            div_ce  <= (state_d == PH_BYPASS) ||
                       ((state_d == PH_HIGH) && (cnt_d == ZERO));
        end
    end

    // R8: active ratio is frozen through a high half
    a_r8_ratio_frozen: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_HIGH) |=> $stable(act_q));

    // R5: half-cycle counter stays within the active ratio
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q != PH_BYPASS) |-> (cnt_q < act_q));

    // R9: bypass is entered only from the low half
    a_r9_bypass_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == PH_BYPASS) |-> ($past(state_q) == PH_LOW));

    // R9: bypass is left only into a high half
    a_r9_bypass_exit: assert property (@(posedge clk) disable iff (rst)
        $fell(state_q == PH_BYPASS) |-> (state_q == PH_HIGH));

    // R6: outside bypass the enable pulses only while the clock is high
    a_r6_ce_in_high: assert property (@(posedge clk) disable iff (rst)
        (div_ce && (state_q != PH_BYPASS)) |-> div_clk);

    // R7: divided clock is low throughout bypass
    a_r7_bypass_low: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_BYPASS) |-> (!div_clk && div_ce));

endmodule

// File: rtl/pclk_prescaler.sv
module pclk_prescaler #(
    parameter int DATA_W     = 16,
    parameter int RATIO_W    = 3,
    parameter int RESET_CODE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_unlock,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              div_clk,
    output logic              div_ce
);

    localparam int PAD_W = DATA_W - RATIO_W;

    logic [RATIO_W-1:0] code_q;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:RATIO_W];

    presc_ctrl_reg #(
        .RATIO_W    (RATIO_W),
        .RESET_CODE (RESET_CODE)
    ) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_unlock (wr_unlock),
        .wr_code   (wdata[RATIO_W-1:0]),
        .code_q    (code_q)
    );

    presc_divider #(
        .RATIO_W    (RATIO_W),
        .RESET_CODE (RESET_CODE)
    ) i_div (
        .clk     (clk),
        .rst     (rst),
        .code    (code_q),
        .div_clk (div_clk),
        .div_ce  (div_ce)
    );

    assign rdata = {{PAD_W{1'b0}}, code_q};

    // R1: after a reset edge the read value is the default code
    a_r1_reset_read: assert property (@(posedge clk)
        rst |=> (rdata == DATA_W'(RESET_CODE)));

endmodule

// File: tb/test_pclk_prescaler.sv
module test_pclk_prescaler;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_unlock = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        div_clk;
    logic        div_ce;

    int n_tests = 0;
    int n_fail  = 0;
    bit chk_en  = 0;

    // reference model: 0 low half, 1 high half, 2 bypass
    int m_state, m_cnt, m_act, m_reg;

    pclk_prescaler i_pclk_prescaler (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_unlock (wr_unlock),
        .wdata     (wdata),
        .rdata     (rdata),
        .div_clk   (div_clk),
        .div_ce    (div_ce)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_clk();
        return (m_state == 1);
    endfunction

    function automatic logic exp_ce();
        return (m_state == 2) || (m_state == 1 && m_cnt == 0);
    endfunction

    function automatic logic [15:0] exp_rdata();
        return {13'b0, 3'(m_reg)};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic model_edge(input bit r, input bit w, input bit u, input logic [15:0] d);
        int old_reg;
        if (r) begin
            m_reg = 2; m_act = 2; m_state = 0; m_cnt = 0;
            return;
        end
        old_reg = m_reg;
        if (w && u) m_reg = int'(d[2:0]);
        case (m_state)
            0: if (m_cnt == m_act - 1) begin
                   m_cnt = 0;
                   if (old_reg == 0) begin m_state = 2; m_act = 0; end
                   else begin m_state = 1; m_act = old_reg; end
               end else m_cnt++;
            1: if (m_cnt == m_act - 1) begin m_state = 0; m_cnt = 0; end
               else m_cnt++;
            default: if (old_reg != 0) begin
                   m_state = 1; m_act = old_reg; m_cnt = 0;
               end
        endcase
    endtask

    task automatic cycle(input bit r, input bit w, input bit u, input logic [15:0] d);
        @(negedge clk);
        if (chk_en) begin
            if (rst) begin
                check("R1 rdata", rdata, exp_rdata());
                check("R1 div_clk", {15'b0, div_clk}, {15'b0, exp_clk()});
                check("R1 div_ce", {15'b0, div_ce}, {15'b0, exp_ce()});
            end else begin
                check("R2 R3 R4 rdata", rdata, exp_rdata());
                check("R5 R8 R9 R10 div_clk", {15'b0, div_clk}, {15'b0, exp_clk()});
                check("R6 R7 div_ce", {15'b0, div_ce}, {15'b0, exp_ce()});
            end
        end
        rst = r; wr_en = w; wr_unlock = u; wdata = d;
        model_edge(r, w, u, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 16'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        cycle(1, 0, 0, 16'h0);
        cycle(1, 0, 0, 16'h0);
        chk_en = 1;
        cycle(1, 0, 0, 16'h0);          // R1 checked here
        // R10: default divide-by-4 after release
        idle(24);
        // R4: locked write ignored
        cycle(0, 1, 0, 16'hFFFD);
        idle(20);
        // R7 R9: enter bypass at boundary
        cycle(0, 1, 1, 16'h0000);
        idle(20);
        // R2 R9: leave bypass, reserved bits read zero
        cycle(0, 1, 1, 16'hA5F7);
        idle(40);
        // R8: mid-period change to code 1
        idle(3);
        cycle(0, 1, 1, 16'h0001);
        idle(20);
        // R5: sweep every code
        for (int c = 0; c < 8; c++) begin
            cycle(0, 1, 1, 16'(c));
            idle(4 * (c + 1) + 4);
        end
        // random phase with one mid-run reset
        for (int i = 0; i < 4000; i++) begin
            bit w, u, r;
            w = (($urandom % 12) == 0);
            u = (($urandom % 2) == 0);
            r = (i == 2000);
            cycle(r, w, u, 16'($urandom));
        end
        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule